// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns one 8-bit character into an asynchronous serial frame on a single output line. The line rests at logic 1 between characters. A frame opens with a low start bit, carries the data byte least-significant bit first, optionally adds one parity bit, and closes with a high stop bit. The parity rule is chosen per character from five options: none, even, odd, constant-one (mark) and constant-zero (space).

Bit timing comes from a divisor input. Every bit lasts exactly that many clock cycles. Characters enter through a valid/ready handshake. The byte, the parity selection and the divisor are all captured in the accepting cycle and are held for the whole frame. A busy flag reports that a frame is in flight.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight, `line_o` is 1, `in_ready_o` is 1 and `busy_o` is 0.
- R2: A character is accepted on a rising clock edge where `in_valid_i` and `in_ready_o` are both 1. From the next cycle on, `line_o` drives the start bit (0) for one bit period.
- R3: After the start bit, the eight data bits follow least-significant bit first. Each bit lasts exactly the captured divisor number of clock cycles, and a divisor of 0 behaves as 1.
- R4: Parity code 1 (even) sends the XOR of the data bits. Data 0x63 gives 0 and data 0xD6 gives 1.
- R5: Parity code 2 (odd) sends the inverse of the even-parity bit.
- R6: Parity code 3 (mark) always sends 1, and parity code 4 (space) always sends 0.
- R7: Parity code 0, and the unused codes 5 to 7, send no parity slot. The stop bit follows bit 7 directly and the frame is 10 bits long.
- R8: With any parity code from 1 to 4, the frame is exactly 11 bits: start, 8 data bits, parity, then the stop bit (1).
- R9: From the cycle after acceptance until the stop bit's full period has elapsed, `in_ready_o` is 0 and `busy_o` is 1. `in_ready_o` is always the complement of `busy_o`.
- R10: Changes on `in_valid_i`, `in_data_i`, `par_mode_i` or `divisor_i` while a frame is in flight have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | A character is offered |
| in_data_i | input | 8 | Character to send |
| par_mode_i | input | 3 | Parity code: 0 none, 1 even, 2 odd, 3 mark, 4 space, 5-7 none |
| divisor_i | input | DIV_W (16) | Clock cycles per bit; 0 acts as 1 |
| in_ready_o | output | 1 | Block can accept a character |
| line_o | output | 1 | Serial output line, idle high |
| busy_o | output | 1 | A frame is being sent |

## Verification
A wrong sequencer state shows up at the line within one bit period. The level on the line takes the wrong value, or a bit boundary moves by a cycle. For this reason the bench compares the line against the expected frame on every clock cycle, not only once per bit. A wrong bit counter or a wrong parity selection changes the frame length, so `in_ready_o` rises early or late at the end of the frame. A wrong divisor capture stretches or shrinks every bit after the start bit. Each of these faults is visible at the ports before the next character can be accepted.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam logic [2:0] PM_NONE  = 3'd0;
    localparam logic [2:0] PM_EVEN  = 3'd1;
    localparam logic [2:0] PM_ODD   = 3'd2;
    localparam logic [2:0] PM_MARK  = 3'd3;
    localparam logic [2:0] PM_SPACE = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;
endpackage

// File: rtl/sertx_parity_gen.sv
module sertx_parity_gen #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [2:0]        mode_i,
    output logic              par_en_o,
    output logic              par_bit_o
);
    import sertx_pkg::*;

    logic even_w;
    assign even_w = ^data_i;

    always_comb begin
        par_en_o  = 1'b1;
        par_bit_o = 1'b0;
        case (mode_i)
            PM_EVEN:  par_bit_o = even_w;
            PM_ODD:   par_bit_o = ~even_w;
            PM_MARK:  par_bit_o = 1'b1;
            PM_SPACE: par_bit_o = 1'b0;
            default:  par_en_o  = 1'b0;
        endcase
    end
endmodule

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o,
    output logic [DIV_W-1:0] cnt_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] rel;
    } tmr_t;

    tmr_t s_d, s_q;
    logic [DIV_W-1:0] rel_new_w;

    assign rel_new_w = (div_i == '0) ? '0 : div_i - 1'b1;
    assign tick_o    = run_i && (s_q.cnt == '0);
    assign cnt_o     = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.cnt = rel_new_w;
            s_d.rel = rel_new_w;
        end else if (run_i) begin
            if (s_q.cnt == '0) s_d.cnt = s_q.rel;
            else               s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic [2:0]        par_mode_i,
    input  logic [DIV_W-1:0]  divisor_i,
    output logic              in_ready_o,
    output logic              line_o,
    output logic              busy_o
);
    import sertx_pkg::*;

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        tx_state_e         st;
        logic [DATA_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
        logic              par_en;
        logic              par_bit;
        logic              line;
    } ctl_t;

    ctl_t c_d, c_q;
    logic accept_w, tick_w, run_w, par_en_w, par_bit_w;
    logic [DIV_W-1:0] cnt_w;

    assign accept_w = in_valid_i && (c_q.st == ST_IDLE);
    assign run_w    = (c_q.st != ST_IDLE);

    sertx_parity_gen #(.DATA_W(DATA_W)) u_par (
        .data_i    (in_data_i),
        .mode_i    (par_mode_i),
        .par_en_o  (par_en_w),
        .par_bit_o (par_bit_w)
    );

    sertx_bit_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (accept_w),
        .run_i  (run_w),
        .div_i  (divisor_i),
        .tick_o (tick_w),
        .cnt_o  (cnt_w)
    );

    always_comb begin
        c_d = c_q;
        case (c_q.st)
            ST_IDLE: begin
                c_d.line = 1'b1;
                if (accept_w) begin
                    c_d.st      = ST_START;
                    c_d.sh      = in_data_i;
                    c_d.par_en  = par_en_w;
                    c_d.par_bit = par_bit_w;
                    c_d.idx     = '0;
                    c_d.line    = 1'b0;
                end
            end
            ST_START: begin
                if (tick_w) begin
                    c_d.st   = ST_DATA;
                    c_d.line = c_q.sh[0];
                    c_d.sh   = c_q.sh >> 1;
                end
            end
            ST_DATA: begin
                if (tick_w) begin
                    if (c_q.idx == LAST_IDX) begin
                        if (c_q.par_en) begin
                            c_d.st   = ST_PAR;
                            c_d.line = c_q.par_bit;
                        end else begin
                            c_d.st   = ST_STOP;
                            c_d.line = 1'b1;
                        end
                    end else begin
                        c_d.idx  = c_q.idx + 1'b1;
                        c_d.line = c_q.sh[0];
                        c_d.sh   = c_q.sh >> 1;
                    end
                end
            end
            ST_PAR: begin
                if (tick_w) begin
                    c_d.st   = ST_STOP;
                    c_d.line = 1'b1;
                end
            end
            ST_STOP: begin
                if (tick_w) begin
                    c_d.st   = ST_IDLE;
                    c_d.line = 1'b1;
                end
            end
            default: begin
                c_d.st   = ST_IDLE;
                c_d.line = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q      <= '0;
            c_q.st   <= ST_IDLE;
            c_q.line <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign line_o     = c_q.line;
    assign busy_o     = (c_q.st != ST_IDLE);
    assign in_ready_o = (c_q.st == ST_IDLE);
endmodule

// File: rtl/sertx_checks.sv
module sertx_checks #(
    parameter int DIV_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             in_valid_i,
    input logic             in_ready_o,
    input logic             line_o,
    input logic             busy_o,
    input logic [DIV_W-1:0] cnt_w
);
    a_r1_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> line_o);

    a_r9_ready_is_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_ready_o == !busy_o);

    a_r2_accept_starts_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_ready_o) |=> (busy_o && !line_o));

    a_r8_stop_bit_before_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> $past(line_o));

    a_r3_line_steady_in_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && ($past(cnt_w) != '0)) |-> $stable(line_o));
endmodule

bind serial_frame_tx sertx_checks #(.DIV_W(DIV_W)) u_sertx_checks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .line_o     (line_o),
    .busy_o     (busy_o),
    .cnt_w      (cnt_w)
);

// File: tb/test_serial_frame_tx.sv
`timescale 1ns/1ps
module test_serial_frame_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic [2:0]  par_mode = '0;
    logic [15:0] divisor = 16'd1;
    logic        in_ready, line, busy;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_frame_tx i_serial_frame_tx (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .in_valid_i (in_valid),
        .in_data_i  (in_data),
        .par_mode_i (par_mode),
        .divisor_i  (divisor),
        .in_ready_o (in_ready),
        .line_o     (line),
        .busy_o     (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sends one character and checks every cycle of its frame.
    task automatic run_frame(input logic [7:0] d, input logic [2:0] m, input int div,
                             input bit junk, input string req);
        logic [10:0] fr;
        int nb, eff;
        bit has_par;
        logic pb;
        eff = (div == 0) ? 1 : div;
        has_par = (m >= 3'd1 && m <= 3'd4);
        case (m)
            3'd1: pb = ^d;
            3'd2: pb = ~^d;
            3'd3: pb = 1'b1;
            default: pb = 1'b0;
        endcase
        fr = '0;
        fr[8:1] = d;
        if (has_par) begin fr[9] = pb; fr[10] = 1'b1; nb = 11; end
        else begin fr[9] = 1'b1; nb = 10; end
        chk(in_ready && !busy && line, {req, " R1 idle before frame"},
            {in_ready, busy, line}, 3'b101);
        in_valid = 1'b1; in_data = d; par_mode = m; divisor = 16'(div);
        @(posedge clk);
        @(negedge clk);
        for (int j = 0; j < nb * eff; j++) begin
            if (junk && j < nb * eff - 1) begin
                in_valid = 1'b1; in_data = ~d; par_mode = m ^ 3'd3;
                divisor = 16'(div + 3);
            end else begin
                in_valid = 1'b0;
            end
            chk(line == fr[j / eff], {req, " line bit (R2 R3)"}, line, fr[j / eff]);
            chk(busy && !in_ready, {req, " R9 busy during frame"}, {busy, in_ready}, 2'b10);
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(in_ready && !busy && line, {req, " R9 ready after stop"},
            {in_ready, busy, line}, 3'b101);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(line == 1'b1 && in_ready && !busy, "R1 reset state", {line, in_ready, busy}, 3'b110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_frame(8'h63, 3'd1, 4, 1'b0, "R4 even 0x63 R8");
        run_frame(8'hD6, 3'd1, 3, 1'b0, "R4 even 0xD6 R8");
        run_frame(8'h63, 3'd2, 2, 1'b0, "R5 odd 0x63");
        run_frame(8'hD6, 3'd2, 1, 1'b0, "R5 odd 0xD6");
        run_frame(8'h00, 3'd3, 1, 1'b0, "R6 mark 0x00");
        run_frame(8'hFF, 3'd4, 5, 1'b0, "R6 space 0xFF");
        run_frame(8'hA5, 3'd0, 3, 1'b0, "R7 none 0xA5");
        run_frame(8'h5A, 3'd6, 2, 1'b0, "R7 unused code");
        run_frame(8'h81, 3'd1, 0, 1'b0, "R3 divisor zero");
        run_frame(8'h3C, 3'd1, 2, 1'b1, "R10 inputs ignored");
        run_frame(8'hC3, 3'd0, 3, 1'b1, "R10 ignored none");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule